// File: doc/BRIEF.md
# Fast system call entry unit

This unit works out the architectural state that a fast system call instruction produces. A start strobe carries a snapshot of the inputs the instruction needs. These are the current instruction pointer, the instruction length, the flags word, the feature-enable bit, the long-mode and 64-bit-code indicators, the selector/target register, the two long-mode entry registers and the flag mask. Two clock edges later the unit presents one of two results. The first is a full set of new values, marked by a one-cycle `done_o` pulse. The second is an invalid-opcode fault, marked by a one-cycle `ud_fault_o` pulse, which leaves every result output unchanged. The surrounding pipeline writes the results into its register file and segment caches.

The controller has three named states. In IDLE it waits for `start_i`. The transition IDLE→EVAL (on start) captures the inputs. EVAL→REPORT is always taken and registers either the results with `done_o` or the fault pulse. REPORT→IDLE is always taken and ends the pulse. A start strobe seen in EVAL or REPORT is dropped. Two datapath variants exist, long mode and legacy mode. They differ in the width of the return address, the rule for clearing flags, whether the saved-flags register is written, and where the entry point comes from.

Top module: `fastcall_entry`

## Requirements
- R1: When `feat_en_i` was 0 at the start strobe, `ud_fault_o` pulses for one cycle, `done_o` stays 0, and every result output keeps its previous value. The fault carries error code 0 and is not reported on any other output.
- R2: A start strobe accepted in IDLE yields exactly one one-cycle pulse of either `done_o` or `ud_fault_o`, two rising edges after the strobe. `done_o` and `ud_fault_o` are never high together. A strobe raised while a request is in flight is ignored.
- R3: Let `sel_base` be bits 47:32 of `tsel_i`. `cs_sel_o` equals `sel_base` with bits 1:0 cleared. `ss_sel_o` equals `(sel_base + 8) mod 2^16` with bits 1:0 cleared.
- R4: The attribute words use bit0 accessed, bit1 readable/writable, bit2 code, bit3 code-or-data, bit4 present, bit5 long, bit6 default-size and bit7 granularity. The stack word is always 0xDB. The code word is 0xBF in long mode and 0xDF in legacy mode. On success `seg_limit_o` becomes 0xFFFFFFFF.
- R5: In long mode `ret_addr_o` is the 64-bit sum `rip_i + ilen_i`. `saved_flags_o` is `rflags_i` with bit 16 (resume) cleared, and `saved_we_o` is 1.
- R6: In long mode `flags_o` is `rflags_i` with every bit that is set in `fmask_i` cleared, and with bit 16 cleared.
- R7: In long mode `ip_o` is `tgt64_i` when `cs64_i` is 1 and `tgtc_i` when it is 0.
- R8: In legacy mode `ret_addr_o` is the low 32 bits of `rip_i + ilen_i`, zero-extended. `flags_o` is `rflags_i` with bits 9 (interrupt enable), 16 (resume) and 17 (virtual-8086) cleared. `saved_we_o` is 0 and `saved_flags_o` keeps its previous value.
- R9: In legacy mode `ip_o` is bits 31:0 of `tsel_i`, zero-extended.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only in IDLE |
| rip_i | input | 64 | Current instruction pointer |
| ilen_i | input | 4 | Instruction length in bytes |
| rflags_i | input | 32 | Current flags word |
| feat_en_i | input | 1 | Fast system call feature enable |
| lma_i | input | 1 | Long mode active |
| cs64_i | input | 1 | Caller runs 64-bit code |
| tsel_i | input | 64 | Selector base in 47:32, legacy target in 31:0 |
| tgt64_i | input | 64 | Long-mode entry point for 64-bit callers |
| tgtc_i | input | 64 | Long-mode entry point for compatibility callers |
| fmask_i | input | 32 | Flag bits to clear in long mode |
| done_o | output | 1 | One-cycle pulse: results valid |
| ud_fault_o | output | 1 | One-cycle pulse: invalid-opcode fault, error code 0 |
| cs_sel_o | output | 16 | New code selector |
| ss_sel_o | output | 16 | New stack selector |
| cs_attr_o | output | 8 | Code segment attribute word |
| ss_attr_o | output | 8 | Stack segment attribute word |
| seg_limit_o | output | 32 | Limit for both new segments |
| ret_addr_o | output | 64 | Value for the return-address register |
| saved_flags_o | output | 32 | Value for the saved-flags register |
| saved_we_o | output | 1 | Saved-flags register is written |
| flags_o | output | 32 | New flags word |
| ip_o | output | 64 | New instruction pointer |

## Verification
Two functions can fall in the same cycle. The fault path and the result-publish path both act on the EVAL→REPORT edge, and a new start strobe can arrive while a request is still being handled. The bench provokes the first case with random requests that clear `feat_en_i` about one time in eight. Each fault has to leave every result output equal to the values of the last successful call, and `done_o` must stay low. For the second case the bench raises a second strobe with different inputs during EVAL. It judges the outcome by the results, which must still match the first request, and by the absence of any second pulse.

// File: rtl/fce_pkg.sv
package fce_pkg;
    // Attribute word bit positions (decoded by the segment cache).
    localparam int ATTR_W  = 8;
    localparam int AB_ACC  = 0;
    localparam int AB_RW   = 1;
    localparam int AB_CODE = 2;
    localparam int AB_SYS  = 3;
    localparam int AB_PRES = 4;
    localparam int AB_LONG = 5;
    localparam int AB_DSZ  = 6;
    localparam int AB_GRAN = 7;

    // Flag bit positions.
    localparam int FB_IF = 9;
    localparam int FB_RF = 16;
    localparam int FB_VM = 17;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_REPORT = 2'd2
    } fce_state_e;
endpackage

// File: rtl/fce_selgen.sv
module fce_selgen
    import fce_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SEL_W   = 16,
    parameter int SEL_LSB = 32
) (
    input  logic [DATA_W-1:0] tsel,
    input  logic              long_mode,
    output logic [SEL_W-1:0]  cs_sel,
    output logic [SEL_W-1:0]  ss_sel,
    output logic [ATTR_W-1:0] cs_attr,
    output logic [ATTR_W-1:0] ss_attr
);
    localparam logic [SEL_W-1:0] RPL_CLR  = ~SEL_W'(3);
    localparam logic [SEL_W-1:0] SS_STEP  = SEL_W'(8);

    logic [SEL_W-1:0] base_sel;
    logic [ATTR_W-1:0] common_attr;

    assign base_sel = tsel[SEL_LSB +: SEL_W];

    always_comb begin
        common_attr = '0;
        common_attr[AB_GRAN] = 1'b1;
        common_attr[AB_PRES] = 1'b1;
        common_attr[AB_SYS]  = 1'b1;
        common_attr[AB_ACC]  = 1'b1;
        common_attr[AB_RW]   = 1'b1;
    end

    always_comb begin
        cs_sel = base_sel & RPL_CLR;
        ss_sel = (base_sel + SS_STEP) & RPL_CLR;

        cs_attr = common_attr;
        cs_attr[AB_CODE] = 1'b1;
        if (long_mode) begin
            cs_attr[AB_LONG] = 1'b1;
        end else begin
            cs_attr[AB_DSZ]  = 1'b1;
        end

        ss_attr = common_attr;
        ss_attr[AB_DSZ] = 1'b1;
    end
endmodule

// File: rtl/fce_flagcalc.sv
module fce_flagcalc
    import fce_pkg::*;
#(
    parameter int FLAG_W = 32
) (
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [FLAG_W-1:0] fmask,
    input  logic              long_mode,
    output logic [FLAG_W-1:0] new_flags,
    output logic [FLAG_W-1:0] saved_flags
);
    logic [FLAG_W-1:0] rf_bit;
    logic [FLAG_W-1:0] legacy_clr;

    always_comb begin
        rf_bit = '0;
        rf_bit[FB_RF] = 1'b1;
        legacy_clr = rf_bit;
        legacy_clr[FB_IF] = 1'b1;
        legacy_clr[FB_VM] = 1'b1;
    end

    always_comb begin
        saved_flags = flags_in & ~rf_bit;
        if (long_mode) begin
            new_flags = flags_in & ~(fmask | rf_bit);
        end else begin
            new_flags = flags_in & ~legacy_clr;
        end
    end
endmodule

// File: rtl/fce_target.sv
module fce_target #(
    parameter int DATA_W   = 64,
    parameter int LEN_W    = 4,
    parameter int NARROW_W = 32
) (
    input  logic [DATA_W-1:0] rip,
    input  logic [LEN_W-1:0]  ilen,
    input  logic [DATA_W-1:0] tsel,
    input  logic [DATA_W-1:0] tgt64,
    input  logic [DATA_W-1:0] tgtc,
    input  logic              long_mode,
    input  logic              cs64,
    output logic [DATA_W-1:0] ret_addr,
    output logic [DATA_W-1:0] entry_ip
);
    localparam int PAD_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] next_ip;

    assign next_ip = rip + DATA_W'(ilen);

    always_comb begin
        if (long_mode) begin
            ret_addr = next_ip;
            entry_ip = cs64 ? tgt64 : tgtc;
        end else begin
            ret_addr = {{PAD_W{1'b0}}, next_ip[NARROW_W-1:0]};
            entry_ip = {{PAD_W{1'b0}}, tsel[NARROW_W-1:0]};
        end
    end
endmodule

// File: rtl/fastcall_entry.sv
module fastcall_entry
    import fce_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int FLAG_W  = 32,
    parameter int LEN_W   = 4,
    parameter int SEL_W   = 16,
    parameter int LIMIT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [DATA_W-1:0]  rip_i,
    input  logic [LEN_W-1:0]   ilen_i,
    input  logic [FLAG_W-1:0]  rflags_i,
    input  logic               feat_en_i,
    input  logic               lma_i,
    input  logic               cs64_i,
    input  logic [DATA_W-1:0]  tsel_i,
    input  logic [DATA_W-1:0]  tgt64_i,
    input  logic [DATA_W-1:0]  tgtc_i,
    input  logic [FLAG_W-1:0]  fmask_i,
    output logic               done_o,
    output logic               ud_fault_o,
    output logic [SEL_W-1:0]   cs_sel_o,
    output logic [SEL_W-1:0]   ss_sel_o,
    output logic [ATTR_W-1:0]  cs_attr_o,
    output logic [ATTR_W-1:0]  ss_attr_o,
    output logic [LIMIT_W-1:0] seg_limit_o,
    output logic [DATA_W-1:0]  ret_addr_o,
    output logic [FLAG_W-1:0]  saved_flags_o,
    output logic               saved_we_o,
    output logic [FLAG_W-1:0]  flags_o,
    output logic [DATA_W-1:0]  ip_o
);
    localparam logic [LIMIT_W-1:0] FLAT_LIMIT = '1;

    fce_state_e state_q, state_nx;

    // Captured request
    logic [DATA_W-1:0] rip_q, tsel_q, tgt64_q, tgtc_q;
    logic [LEN_W-1:0]  ilen_q;
    logic [FLAG_W-1:0] rflags_q, fmask_q;
    logic              feat_q, lma_q, cs64_q;

    // Datapath results
    logic [SEL_W-1:0]  cs_sel_c, ss_sel_c;
    logic [ATTR_W-1:0] cs_attr_c, ss_attr_c;
    logic [FLAG_W-1:0] new_flags_c, saved_flags_c;
    logic [DATA_W-1:0] ret_addr_c, entry_ip_c;

    logic accept;
    assign accept = (state_q == ST_IDLE) && start_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_nx = ST_EVAL;
            ST_EVAL:   state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rip_q    <= '0;
            tsel_q   <= '0;
            tgt64_q  <= '0;
            tgtc_q   <= '0;
            ilen_q   <= '0;
            rflags_q <= '0;
            fmask_q  <= '0;
            feat_q   <= 1'b0;
            lma_q    <= 1'b0;
            cs64_q   <= 1'b0;
        end else if (accept) begin
            rip_q    <= rip_i;
            tsel_q   <= tsel_i;
            tgt64_q  <= tgt64_i;
            tgtc_q   <= tgtc_i;
            ilen_q   <= ilen_i;
            rflags_q <= rflags_i;
            fmask_q  <= fmask_i;
            feat_q   <= feat_en_i;
            lma_q    <= lma_i;
            cs64_q   <= cs64_i;
        end
    end

    fce_selgen #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_selgen (
        .tsel      (tsel_q),
        .long_mode (lma_q),
        .cs_sel    (cs_sel_c),
        .ss_sel    (ss_sel_c),
        .cs_attr   (cs_attr_c),
        .ss_attr   (ss_attr_c)
    );

    fce_flagcalc #(
        .FLAG_W (FLAG_W)
    ) u_flagcalc (
        .flags_in    (rflags_q),
        .fmask       (fmask_q),
        .long_mode   (lma_q),
        .new_flags   (new_flags_c),
        .saved_flags (saved_flags_c)
    );

    fce_target #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_target (
        .rip       (rip_q),
        .ilen      (ilen_q),
        .tsel      (tsel_q),
        .tgt64     (tgt64_q),
        .tgtc      (tgtc_q),
        .long_mode (lma_q),
        .cs64      (cs64_q),
        .ret_addr  (ret_addr_c),
        .entry_ip  (entry_ip_c)
    );

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o        <= 1'b0;
            ud_fault_o    <= 1'b0;
            cs_sel_o      <= '0;
            ss_sel_o      <= '0;
            cs_attr_o     <= '0;
            ss_attr_o     <= '0;
            seg_limit_o   <= '0;
            ret_addr_o    <= '0;
            saved_flags_o <= '0;
            saved_we_o    <= 1'b0;
            flags_o       <= '0;
            ip_o          <= '0;
        end else begin
            done_o     <= 1'b0;
            ud_fault_o <= 1'b0;
            if (state_q == ST_EVAL) begin
                if (!feat_q) begin
                    ud_fault_o <= 1'b1;
                end else begin
                    done_o      <= 1'b1;
                    cs_sel_o    <= cs_sel_c;
                    ss_sel_o    <= ss_sel_c;
                    cs_attr_o   <= cs_attr_c;
                    ss_attr_o   <= ss_attr_c;
                    seg_limit_o <= FLAT_LIMIT;
                    ret_addr_o  <= ret_addr_c;
                    flags_o     <= new_flags_c;
                    ip_o        <= entry_ip_c;
                    saved_we_o  <= lma_q;
                    if (lma_q) begin
                        saved_flags_o <= saved_flags_c;
                    end
                end
            end
        end
    end

    // R2
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && ud_fault_o));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 (done_o || ud_fault_o));

    // R1
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault_o |-> ($stable(ip_o) && $stable(flags_o) && $stable(ret_addr_o)
                        && $stable(cs_sel_o) && $stable(saved_flags_o)));

    // R3
    sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_sel_o[1:0] == 2'b00 && ss_sel_o == cs_sel_o + SEL_W'(8)));

    // R4
    cs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_attr_o[AB_LONG] != cs_attr_o[AB_DSZ]));

    // R6
    rf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !flags_o[FB_RF]);

    // R8
    legacy_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !saved_we_o) |-> $stable(saved_flags_o));
endmodule

// File: tb/fastcall_entry_tb.sv
module fastcall_entry_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] rip_i = '0, tsel_i = '0, tgt64_i = '0, tgtc_i = '0;
    logic [3:0]  ilen_i = '0;
    logic [31:0] rflags_i = '0, fmask_i = '0;
    logic        feat_en_i = 1'b0, lma_i = 1'b0, cs64_i = 1'b0;
    logic        done_o, ud_fault_o, saved_we_o;
    logic [15:0] cs_sel_o, ss_sel_o;
    logic [7:0]  cs_attr_o, ss_attr_o;
    logic [31:0] seg_limit_o, saved_flags_o, flags_o;
    logic [63:0] ret_addr_o, ip_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Model state (previous published values)
    logic [15:0] m_cs, m_ss;
    logic [7:0]  m_csa, m_ssa;
    logic [31:0] m_lim, m_sflags, m_flags;
    logic [63:0] m_ret, m_ip;
    logic        m_we;

    always #5 clk = ~clk;

    fastcall_entry u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rip_i(rip_i), .ilen_i(ilen_i),
        .rflags_i(rflags_i), .feat_en_i(feat_en_i), .lma_i(lma_i), .cs64_i(cs64_i),
        .tsel_i(tsel_i), .tgt64_i(tgt64_i), .tgtc_i(tgtc_i), .fmask_i(fmask_i),
        .done_o(done_o), .ud_fault_o(ud_fault_o), .cs_sel_o(cs_sel_o), .ss_sel_o(ss_sel_o),
        .cs_attr_o(cs_attr_o), .ss_attr_o(ss_attr_o), .seg_limit_o(seg_limit_o),
        .ret_addr_o(ret_addr_o), .saved_flags_o(saved_flags_o), .saved_we_o(saved_we_o),
        .flags_o(flags_o), .ip_o(ip_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] f_ss(input logic [63:0] t);
        return (t[47:32] + 16'd8) & 16'hFFFC;
    endfunction

    // Update model for a request
    task automatic model(output bit fault);
        logic [31:0] clr;
        fault = !feat_en_i;
        if (fault) return;
        m_cs  = tsel_i[47:32] & 16'hFFFC;               // R3
        m_ss  = f_ss(tsel_i);
        m_ssa = 8'hDB;                                  // R4
        m_csa = lma_i ? 8'hBF : 8'hDF;
        m_lim = 32'hFFFF_FFFF;
        if (lma_i) begin
            m_ret = rip_i + 64'(ilen_i);                // R5
            m_sflags = rflags_i & ~32'h0001_0000;
            m_we = 1'b1;
            m_flags = rflags_i & ~(fmask_i | 32'h0001_0000); // R6
            m_ip = cs64_i ? tgt64_i : tgtc_i;           // R7
        end else begin
            logic [63:0] s;
            s = rip_i + 64'(ilen_i);
            m_ret = {32'h0, s[31:0]};                   // R8
            m_we = 1'b0;
            clr = 32'h0003_0200;
            m_flags = rflags_i & ~clr;
            m_ip = {32'h0, tsel_i[31:0]};               // R9
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "cs_sel", 64'(cs_sel_o), 64'(m_cs));
        chk(req, "ss_sel", 64'(ss_sel_o), 64'(m_ss));
        chk(req, "cs_attr", 64'(cs_attr_o), 64'(m_csa));
        chk(req, "ss_attr", 64'(ss_attr_o), 64'(m_ssa));
        chk(req, "limit", 64'(seg_limit_o), 64'(m_lim));
        chk(req, "ret_addr", ret_addr_o, m_ret);
        chk(req, "saved_flags", 64'(saved_flags_o), 64'(m_sflags));
        chk(req, "saved_we", 64'(saved_we_o), 64'(m_we));
        chk(req, "flags", 64'(flags_o), 64'(m_flags));
        chk(req, "ip", ip_o, m_ip);
    endtask

    // Issue a request using the current input values; optionally inject a
    // second strobe while busy.
    task automatic run(input string req, input bit busy_poke);
        bit fault;
        model(fault);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = busy_poke;
        if (busy_poke) begin
            rip_i = ~rip_i; tsel_i = ~tsel_i; feat_en_i = ~feat_en_i; lma_i = ~lma_i;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", "done", 64'(done_o), 64'(!fault));
        chk(fault ? "R1" : "R2", "ud_fault", 64'(ud_fault_o), 64'(fault));
        compare_all(fault ? "R1" : req);
        @(negedge clk);
        chk("R2", "done_single", 64'(done_o), 64'd0);
        chk("R2", "fault_single", 64'(ud_fault_o), 64'd0);
        if (busy_poke) begin
            @(negedge clk);
            chk("R2", "busy_no_done", 64'(done_o | ud_fault_o), 64'd0);
            @(negedge clk);
            chk("R2", "busy_no_done2", 64'(done_o | ud_fault_o), 64'd0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cs = '0; m_ss = '0; m_csa = '0; m_ssa = '0; m_lim = '0;
        m_sflags = '0; m_flags = '0; m_ret = '0; m_ip = '0; m_we = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        compare_all("R10");
        chk("R10", "done", 64'(done_o), 64'd0);
        chk("R10", "fault", 64'(ud_fault_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Long mode 64-bit caller, R5 R6 R7
        feat_en_i = 1; lma_i = 1; cs64_i = 1; rip_i = 64'hFFFF_FFFF_FFFF_FFFE; ilen_i = 4'd2;
        rflags_i = 32'h0003_0202; fmask_i = 32'h0000_0700;
        tsel_i = 64'h0023_0010_DEAD_BEEF; tgt64_i = 64'hFFFF_8000_0000_1000;
        tgtc_i = 64'h0000_0000_C000_0000;
        run("R7", 0);
        // Compatibility caller, R7
        cs64_i = 0;
        run("R7", 0);
        // Fault after a success: outputs held, R1
        feat_en_i = 0; tsel_i = 64'h1111_2222_3333_4444;
        run("R1", 0);
        // Legacy with 32-bit wrap of return address, R8 R9
        feat_en_i = 1; lma_i = 0; rip_i = 64'h0000_0001_FFFF_FFFE; ilen_i = 4'd3;
        rflags_i = 32'hFFFF_FFFF; tsel_i = 64'h0000_FFF8_8000_0000;
        run("R8", 0);
        // Selector wrap at 0xFFF8 / 0xFFFB, R3
        lma_i = 1; cs64_i = 1; tsel_i = 64'h0000_FFFB_0000_0000;
        run("R3", 0);
        // Start while busy ignored, R2
        rip_i = 64'h1234; tsel_i = 64'h0000_0040_0000_0000;
        run("R2", 1);

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            rip_i = {$urandom, $urandom}; ilen_i = 4'($urandom);
            rflags_i = $urandom; fmask_i = $urandom;
            feat_en_i = ($urandom % 8) != 0; lma_i = 1'($urandom); cs64_i = 1'($urandom);
            tsel_i = {$urandom, $urandom}; tgt64_i = {$urandom, $urandom};
            tgtc_i = {$urandom, $urandom};
            run(lma_i ? "R6" : "R9", ((i % 37) == 5));
        end
        finish_run();
    end
endmodule